// File: doc/BRIEF.md
# Priority-Level Banked Register File

This block holds the working registers of a small controller that has four execution levels, 0 to 3. Each level owns a private bank of sixteen 16-bit registers. Register 0 of a bank is the program counter of that level. When the active level changes, the visible program counter changes with it, and the controller resumes each level exactly where that level stopped. No vector is fetched and nothing is saved or restored.

Three hardware request lines drive the level selection. Line k asks for level k+1, and level 3 ranks highest. At every instruction boundary, which the controller marks with a one-cycle strobe, the block selects the highest level whose request is still asserted. With no request asserted it selects level 0. A level therefore keeps control as long as its own request stays high and no higher request arrives. It gives up control at the first boundary after its request drops.

Two combinational read ports and one write port serve the current level. A byte-wide memory port exposes all four banks as the lowest 128 bytes of the address space. Code at any level can therefore inspect or patch another level's registers, including that level's program counter.

Top module: `prio_bank_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register of every bank to zero and sets the current level to 0.
- R2: On a cycle with the boundary strobe high, the level after the clock edge is the highest asserted request: irq_i[2] gives 3, else irq_i[1] gives 2, else irq_i[0] gives 1, else 0.
- R3: On a cycle with the boundary strobe low, the level does not change, whatever the request lines do.
- R4: Both read ports return, in the same cycle, the register of the current level's bank selected by their index. A processor write stores its full 16-bit word in the current level's bank at the clock edge and leaves the other banks unchanged.
- R5: pc_o always shows register 0 of the current level's bank, so a level change switches the program counter with no other action.
- R6: A bus read of byte address A returns, combinationally, register A[4:1] of bank A[6:5]. It returns the high byte when A[0]=0 and the low byte when A[0]=1.
- R7: A bus write to byte address A stores the byte into that location at the clock edge, in any bank, and leaves the register's other byte unchanged.
- R8: When a processor write and a bus write hit the same byte in one cycle, the processor data is stored. A bus write to a different byte in the same cycle still takes effect.
- R9: A bus write made at a higher level into the alias of bank 0, register 0 changes the program counter that level 0 shows when it resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Instruction-boundary strobe; the level may change only when it is high |
| irq_i | input | 3 | Level requests; bit k asks for level k+1 |
| level_o | output | 2 | Current execution level |
| pc_o | output | 16 | Register 0 of the current level's bank |
| rd_a_idx_i | input | 4 | Register index for read port A |
| rd_a_data_o | output | 16 | Read port A data |
| rd_b_idx_i | input | 4 | Register index for read port B |
| rd_b_data_o | output | 16 | Read port B data |
| wr_en_i | input | 1 | Processor write enable |
| wr_idx_i | input | 4 | Processor write register index |
| wr_data_i | input | 16 | Processor write data |
| bus_addr_i | input | 7 | Byte address inside the 128-byte alias window |
| bus_we_i | input | 1 | Bus byte write enable |
| bus_wdata_i | input | 8 | Bus write byte |
| bus_rdata_o | output | 8 | Bus read byte |

## Verification
The level selection is tried with all eight request patterns at a boundary. These patterns show whether the priority order is right and whether each lower line is masked by every higher one. Requests that rise and fall between boundaries show whether the selection is sampled only at the strobe. Register traffic is run at two levels with the same index, which shows whether the banks are separate. Bus accesses to both byte lanes in several banks show whether the address split is right and which byte is which. Same-cycle processor and bus writes are run once on the same byte and once on different bytes, which shows the write priority and also shows that a colliding bus write is not dropped everywhere.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

    parameter int unsigned NUM_LEVELS = 4;
    parameter int unsigned NUM_REGS   = 16;
    parameter int unsigned REG_W      = 16;

    localparam int unsigned LVL_W       = $clog2(NUM_LEVELS);
    localparam int unsigned IDX_W       = $clog2(NUM_REGS);
    localparam int unsigned LANES       = REG_W / 8;
    localparam int unsigned LANE_W      = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned NUM_IRQ     = NUM_LEVELS - 1;
    localparam int unsigned ALIAS_BYTES = NUM_LEVELS * NUM_REGS * LANES;
    localparam int unsigned ALIAS_AW    = $clog2(ALIAS_BYTES);

    typedef logic [LVL_W-1:0]   level_t;
    typedef logic [IDX_W-1:0]   reg_idx_t;
    typedef logic [REG_W-1:0]   word_t;
    typedef logic [7:0]         byte_t;
    typedef logic [LANE_W-1:0]  lane_t;
    typedef logic [NUM_IRQ-1:0] req_t;

    // Whole register file, bank-major
    typedef logic [NUM_LEVELS-1:0][NUM_REGS-1:0][REG_W-1:0] file_t;

    // Alias location: bank in the top bits, register next, lane 0 = most significant byte
    typedef struct packed {
        level_t   bank;
        reg_idx_t idx;
        lane_t    lane;
    } alias_loc_t;

    typedef struct packed {
        logic     en;
        level_t   bank;
        reg_idx_t idx;
        word_t    data;
    } cpu_wr_t;

    typedef struct packed {
        logic       en;
        alias_loc_t loc;
        byte_t      data;
    } bus_wr_t;

    function automatic alias_loc_t decode_alias(input logic [ALIAS_AW-1:0] addr);
        return alias_loc_t'(addr);
    endfunction

    // Highest asserted request wins; none asserted selects level 0
    function automatic level_t pick_level(input req_t req);
        level_t lvl;
        lvl = '0;
        for (int i = 0; i < int'(NUM_IRQ); i++) begin
            if (req[i]) lvl = level_t'(i + 1);
        end
        return lvl;
    endfunction

    // Bit offset of a byte lane inside a register word
    function automatic int unsigned lane_lsb(input int unsigned lane);
        return (LANES - 1 - lane) * 8;
    endfunction

endpackage

// File: rtl/prio_level_arbiter.sv
module prio_level_arbiter
    import prio_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance_i,
    input  req_t   req_i,
    output level_t level_o
);

    level_t level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (advance_i) begin
            level_q <= pick_level(req_i);
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/prio_bank_array.sv
module prio_bank_array
    import prio_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cpu_wr_t cpu_wr_i,
    input  bus_wr_t bus_wr_i,
    output file_t   file_o
);

    for (genvar b = 0; b < int'(NUM_LEVELS); b++) begin : g_bank
        for (genvar r = 0; r < int'(NUM_REGS); r++) begin : g_reg
            for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
                localparam int unsigned LSB = lane_lsb(l);

                byte_t cell_q;
                logic  cpu_hit;
                logic  bus_hit;

                assign cpu_hit = cpu_wr_i.en
                              && (cpu_wr_i.bank == level_t'(b))
                              && (cpu_wr_i.idx  == reg_idx_t'(r));
                assign bus_hit = bus_wr_i.en
                              && (bus_wr_i.loc.bank == level_t'(b))
                              && (bus_wr_i.loc.idx  == reg_idx_t'(r))
                              && (bus_wr_i.loc.lane == lane_t'(l));

                // Processor port has priority over the memory alias port
                always_ff @(posedge clk) begin
                    if (rst) begin
                        cell_q <= '0;
                    end else if (cpu_hit) begin
                        cell_q <= cpu_wr_i.data[LSB +: 8];
                    end else if (bus_hit) begin
                        cell_q <= bus_wr_i.data;
                    end
                end

                assign file_o[b][r][LSB +: 8] = cell_q;
            end
        end
    end

endmodule

// File: rtl/prio_read_mux.sv
module prio_read_mux
    import prio_bank_pkg::*;
(
    input  file_t      file_i,
    input  level_t     level_i,
    input  reg_idx_t   rd_a_idx_i,
    input  reg_idx_t   rd_b_idx_i,
    input  alias_loc_t bus_loc_i,
    output word_t      rd_a_o,
    output word_t      rd_b_o,
    output word_t      pc_o,
    output byte_t      bus_byte_o
);

    word_t bus_word;

    always_comb begin
        rd_a_o     = file_i[level_i][rd_a_idx_i];
        rd_b_o     = file_i[level_i][rd_b_idx_i];
        pc_o       = file_i[level_i][0];
        bus_word   = file_i[bus_loc_i.bank][bus_loc_i.idx];
        bus_byte_o = bus_word[lane_lsb(int'(bus_loc_i.lane)) +: 8];
    end

endmodule

// File: rtl/prio_bank_regfile.sv
module prio_bank_regfile
    import prio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step_i,
    input  logic [NUM_IRQ-1:0]  irq_i,
    output logic [LVL_W-1:0]    level_o,
    output logic [REG_W-1:0]    pc_o,
    input  logic [IDX_W-1:0]    rd_a_idx_i,
    output logic [REG_W-1:0]    rd_a_data_o,
    input  logic [IDX_W-1:0]    rd_b_idx_i,
    output logic [REG_W-1:0]    rd_b_data_o,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [ALIAS_AW-1:0] bus_addr_i,
    input  logic                bus_we_i,
    input  logic [7:0]          bus_wdata_i,
    output logic [7:0]          bus_rdata_o
);

    level_t     cur_level;
    file_t      file_q;
    cpu_wr_t    cpu_wr;
    bus_wr_t    bus_wr;
    alias_loc_t bus_loc;

    assign bus_loc = decode_alias(bus_addr_i);

    always_comb begin
        cpu_wr.en   = wr_en_i;
        cpu_wr.bank = cur_level;
        cpu_wr.idx  = wr_idx_i;
        cpu_wr.data = wr_data_i;
        bus_wr.en   = bus_we_i;
        bus_wr.loc  = bus_loc;
        bus_wr.data = bus_wdata_i;
    end

    prio_level_arbiter u_arbiter (
        .clk       (clk),
        .rst       (rst),
        .advance_i (step_i),
        .req_i     (irq_i),
        .level_o   (cur_level)
    );

    prio_bank_array u_array (
        .clk      (clk),
        .rst      (rst),
        .cpu_wr_i (cpu_wr),
        .bus_wr_i (bus_wr),
        .file_o   (file_q)
    );

    prio_read_mux u_mux (
        .file_i     (file_q),
        .level_i    (cur_level),
        .rd_a_idx_i (rd_a_idx_i),
        .rd_b_idx_i (rd_b_idx_i),
        .bus_loc_i  (bus_loc),
        .rd_a_o     (rd_a_data_o),
        .rd_b_o     (rd_b_data_o),
        .pc_o       (pc_o),
        .bus_byte_o (bus_rdata_o)
    );

    assign level_o = cur_level;

endmodule

// File: rtl/prio_bank_regfile_chk.sv
module prio_bank_regfile_chk
    import prio_bank_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                step_i,
    input logic [NUM_IRQ-1:0]  irq_i,
    input logic [LVL_W-1:0]    level_o,
    input logic [REG_W-1:0]    pc_o,
    input logic                wr_en_i,
    input logic [IDX_W-1:0]    wr_idx_i,
    input logic [REG_W-1:0]    wr_data_i,
    input logic [ALIAS_AW-1:0] bus_addr_i,
    input logic                bus_we_i,
    input logic [7:0]          bus_wdata_i
);

    // R1
    reset_level_chk: assert property (@(posedge clk)
        rst |=> (level_o == '0 && pc_o == '0));

    // R2
    top_request_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && irq_i[NUM_IRQ-1]) |=> (level_o == LVL_W'(NUM_LEVELS - 1)));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && irq_i == '0) |=> (level_o == '0));

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(level_o));

    // R5
    pc_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i == '0 && !step_i) |=> (pc_o == $past(wr_data_i)));

    // R7
    alias_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && !wr_en_i && !step_i
         && bus_addr_i == ALIAS_AW'(32'(level_o) * NUM_REGS * LANES))
        |=> (pc_o[REG_W-1 -: 8] == $past(bus_wdata_i)));

endmodule

bind prio_bank_regfile prio_bank_regfile_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step_i),
    .irq_i       (irq_i),
    .level_o     (level_o),
    .pc_o        (pc_o),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i)
);

// File: tb/test_prio_bank_regfile.sv
module test_prio_bank_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        step_i;
    logic [2:0]  irq_i;
    logic [1:0]  level_o;
    logic [15:0] pc_o;
    logic [3:0]  rd_a_idx_i;
    logic [15:0] rd_a_data_o;
    logic [3:0]  rd_b_idx_i;
    logic [15:0] rd_b_data_o;
    logic        wr_en_i;
    logic [3:0]  wr_idx_i;
    logic [15:0] wr_data_i;
    logic [6:0]  bus_addr_i;
    logic        bus_we_i;
    logic [7:0]  bus_wdata_i;
    logic [7:0]  bus_rdata_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    prio_bank_regfile i_prio_bank_regfile (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step_i),
        .irq_i       (irq_i),
        .level_o     (level_o),
        .pc_o        (pc_o),
        .rd_a_idx_i  (rd_a_idx_i),
        .rd_a_data_o (rd_a_data_o),
        .rd_b_idx_i  (rd_b_idx_i),
        .rd_b_data_o (rd_b_data_o),
        .wr_en_i     (wr_en_i),
        .wr_idx_i    (wr_idx_i),
        .wr_data_i   (wr_data_i),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        step_i = 0; irq_i = 0; rd_a_idx_i = 0; rd_b_idx_i = 0;
        wr_en_i = 0; wr_idx_i = 0; wr_data_i = 0;
        bus_addr_i = 0; bus_we_i = 0; bus_wdata_i = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic go_level(input int lvl);
        irq_i = (lvl == 0) ? 3'b000 : 3'(1 << (lvl - 1));
        step_i = 1; tick(); step_i = 0;
    endtask

    task automatic cpu_write(input int idx, input logic [15:0] d);
        wr_en_i = 1; wr_idx_i = 4'(idx); wr_data_i = d; tick(); wr_en_i = 0;
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        bus_we_i = 1; bus_addr_i = 7'(a); bus_wdata_i = d; tick(); bus_we_i = 0;
    endtask

    task automatic read_reg(input int idx, output logic [15:0] v);
        rd_a_idx_i = 4'(idx); #1 v = rd_a_data_o;
    endtask

    task automatic bus_read(input int a, output logic [7:0] v);
        bus_addr_i = 7'(a); #1 v = bus_rdata_o;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        logic [7:0]  b;
        int nz;
        cpu_write(3, 16'h5555);
        bus_write(100, 8'h77);
        go_level(2);
        do_reset();
        chk("R1 level", 16'(level_o), 16'h0);
        chk("R1 pc", pc_o, 16'h0);
        nz = 0;
        for (int a = 0; a < 128; a++) begin
            bus_read(a, b);
            if (b != 0) nz++;
        end
        chk("R1 all bytes zero", 16'(nz), 16'h0);
        read_reg(3, v);
        chk("R1 reg3", v, 16'h0);
    endtask

    task automatic t_priority();
        logic [1:0] exp_lvl [8] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3, 2'd3, 2'd3};
        do_reset();
        for (int p = 0; p < 8; p++) begin
            irq_i = 3'(p); step_i = 1; tick(); step_i = 0;
            chk($sformatf("R2 irq=%0d", p), 16'(level_o), 16'(exp_lvl[p]));
        end
    endtask

    task automatic t_hold();
        do_reset();
        irq_i = 3'b100;
        tick(); tick(); tick();
        chk("R3 no strobe keeps 0", 16'(level_o), 16'h0);
        step_i = 1; tick(); step_i = 0;
        chk("R3 strobe takes 3", 16'(level_o), 16'h3);
        irq_i = 3'b000; tick(); tick();
        chk("R3 dropped request held", 16'(level_o), 16'h3);
        step_i = 1; tick(); step_i = 0;
        chk("R3 release to 0", 16'(level_o), 16'h0);
        go_level(1); go_level(1); go_level(1);
        chk("R2 own request keeps 1", 16'(level_o), 16'h1);
    endtask

    task automatic t_ports();
        logic [15:0] v;
        do_reset();
        for (int r = 1; r < 16; r++) cpu_write(r, 16'(16'h1000 + r * 16'h0111));
        rd_a_idx_i = 4'd5; rd_b_idx_i = 4'd9; #1;
        chk("R4 port A reg5", rd_a_data_o, 16'h1555);
        chk("R4 port B reg9", rd_b_data_o, 16'h1999);
        go_level(1);
        read_reg(5, v);
        chk("R4 bank1 separate", v, 16'h0000);
        cpu_write(5, 16'hBEEF);
        read_reg(5, v);
        chk("R4 bank1 write", v, 16'hBEEF);
        go_level(0);
        read_reg(5, v);
        chk("R4 bank0 kept", v, 16'h1555);
    endtask

    task automatic t_alias();
        logic [7:0]  b;
        logic [15:0] v;
        do_reset();
        go_level(2);
        cpu_write(7, 16'hA55A);
        bus_read(78, b); chk("R6 bank2 reg7 high", 16'(b), 16'h00A5);
        bus_read(79, b); chk("R6 bank2 reg7 low", 16'(b), 16'h005A);
        go_level(0);
        bus_write(105, 8'h77);
        bus_write(104, 8'h66);
        cpu_write(9, 16'hABCD);
        bus_write(18, 8'h11);
        read_reg(9, v);
        chk("R7 high byte only", v, 16'h11CD);
        go_level(3);
        read_reg(4, v);
        chk("R7 bank3 reg4", v, 16'h6677);
    endtask

    task automatic t_conflict();
        logic [15:0] v;
        do_reset();
        go_level(1);
        wr_en_i = 1; wr_idx_i = 4'd3; wr_data_i = 16'hCAFE;
        bus_we_i = 1; bus_addr_i = 7'd38; bus_wdata_i = 8'h00;
        tick();
        wr_en_i = 0; bus_we_i = 0;
        read_reg(3, v);
        chk("R8 processor wins", v, 16'hCAFE);
        wr_en_i = 1; wr_idx_i = 4'd3; wr_data_i = 16'h1234;
        bus_we_i = 1; bus_addr_i = 7'd41; bus_wdata_i = 8'h9C;
        tick();
        wr_en_i = 0; bus_we_i = 0;
        read_reg(3, v);
        chk("R8 cpu part", v, 16'h1234);
        read_reg(4, v);
        chk("R8 bus part lands", v, 16'h009C);
    endtask

    task automatic t_resume();
        do_reset();
        cpu_write(0, 16'h0100);
        chk("R5 level0 pc", pc_o, 16'h0100);
        go_level(2);
        chk("R5 level2 pc fresh", pc_o, 16'h0000);
        cpu_write(0, 16'h0400);
        chk("R5 level2 pc", pc_o, 16'h0400);
        bus_write(0, 8'h02);
        bus_write(1, 8'h40);
        chk("R9 own pc untouched", pc_o, 16'h0400);
        go_level(0);
        chk("R9 level0 resumes patched", pc_o, 16'h0240);
        go_level(2);
        chk("R5 level2 pc kept", pc_o, 16'h0400);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        tick(); tick(); tick();
        rst = 0;
        t_reset();
        t_priority();
        t_hold();
        t_ports();
        t_alias();
        t_conflict();
        t_resume();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule